// File: doc/BRIEF.md
# Bit-plane transposer with zero-run coder

This block is the front end of a lossless compressor for detector pixel streams. Pixels arrive one per handshake and are collected into groups. Each group is turned on its side. The first output byte carries the least significant bit of every pixel in the group, the next byte carries the next bit up, and so on to the most significant bit. The high-order bits of typical pixel data are mostly zero and vary little between neighbours, so this regrouping produces long stretches of zero bytes.

A tokeniser follows the transposer. Each nonzero byte is passed through as a literal token. A stretch of zero bytes becomes a single run token that gives its length. The input is a valid/ready pixel stream with a frame-end flag. The output is a valid/ready stream of 9-bit tokens.

There are two group buffers. One buffer can fill while the other is still being read out plane by plane. A downstream decoder can rebuild every pixel exactly from the token stream.

Top module: `bpz_top`

## Requirements
- R1: After reset is released, `tok_valid` is 0 and `in_ready` is 1.
- R2: Each group of 8 pixels of 16 bits produces exactly 16 bytes. Byte k (k = 0 first, up to 15) holds bit k of the group's pixels, with pixel j (arrival order, 0 first) in bit j of the byte.
- R3: When `in_last` closes a group of fewer than 8 pixels, the missing pixel positions are treated as zero. The next accepted pixel starts a fresh group.
- R4: A nonzero byte b is emitted as the token `{1'b0, b}`: bit 8 is 0 and bits 7..0 equal b.
- R5: A run of m zero bytes (1 ≤ m ≤ 256) is emitted as the token `{1'b1, m-1}`. When a run reaches 256 bytes, its token is emitted at once and any further zero byte begins a new run.
- R6: A pending zero run is emitted before the literal for the next nonzero byte. It is also emitted when the last byte of a frame has been taken in, so no run spans two frames.
- R7: While `tok_valid` is 1 and `tok_ready` is 0, `tok_valid` stays 1 and `tok_data` holds its value.
- R8: `in_ready` falls only when both group buffers hold groups that are not yet fully read out. With the output blocked and every byte nonzero, exactly 16 pixels are accepted before the input stalls.
- R9: Under any mix of frame lengths, pixel values, input gaps and output backpressure, the token stream equals the one given by R2 to R6, with nothing lost, repeated or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Pixel available |
| in_ready | output | 1 | Block can take a pixel |
| in_data | input | 16 | Pixel value |
| in_last | input | 1 | This pixel ends the frame |
| tok_valid | output | 1 | Token available |
| tok_ready | input | 1 | Downstream takes the token |
| tok_data | output | 9 | Token: bit 8 is the kind (0 literal, 1 zero run), bits 7..0 are the byte or the run length minus one |

## Verification
The bench builds the block at its default parameters: 16-bit pixels, groups of 8, and a run limit of 256. These values keep the run limit within easy reach. A frame of 128 zero pixels gives exactly 256 zero bytes, which must produce one full-length run and no leftover token. A frame of 160 zero pixels crosses the limit and leaves a remainder. Single-pixel frames exercise padding and the bit position of each pixel. A blocked output with all-ones pixels exposes the exact depth of the double buffer.

// File: rtl/bpz_pkg.sv
package bpz_pkg;
  // Kind bit carried in the top position of every output token.
  typedef enum logic {
    TK_LIT = 1'b0,
    TK_RUN = 1'b1
  } tok_kind_e;
endpackage

// File: rtl/bpz_rst_sync.sv
module bpz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bpz_group_buf.sv
module bpz_group_buf #(
  parameter int unsigned PIX_W = 16,
  parameter int unsigned GRP   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_last,
  output logic             pl_valid,
  input  logic             pl_ready,
  output logic [GRP-1:0]   pl_data,
  output logic             pl_last
);
  localparam int unsigned CNT_W = $clog2(GRP);
  localparam int unsigned PL_W  = $clog2(PIX_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP - 1);
  localparam logic [PL_W-1:0]  PL_LAST  = PL_W'(PIX_W - 1);

  logic [PIX_W-1:0] mem_q [2][GRP];
  logic [1:0]       full_q, full_d;
  logic [1:0]       flast_q, flast_d;
  logic             wr_sel_q, wr_sel_d;
  logic             rd_sel_q, rd_sel_d;
  logic [CNT_W-1:0] wr_cnt_q, wr_cnt_d;
  logic [PL_W-1:0]  plane_q, plane_d;

  logic in_fire, grp_close, pl_fire, grp_done;

  assign in_ready  = !full_q[wr_sel_q];
  assign in_fire   = in_valid && in_ready;
  assign grp_close = in_fire && (in_last || (wr_cnt_q == CNT_LAST));
  assign pl_valid  = full_q[rd_sel_q];
  assign pl_fire   = pl_valid && pl_ready;
  assign grp_done  = pl_fire && (plane_q == PL_LAST);
  assign pl_last   = flast_q[rd_sel_q] && (plane_q == PL_LAST);

  // Transpose: byte bit j is the selected plane of pixel j.
  for (genvar j = 0; j < GRP; j++) begin : g_tp
    assign pl_data[j] = mem_q[rd_sel_q][j][plane_q];
  end

  always_comb begin
    full_d   = full_q;
    flast_d  = flast_q;
    wr_sel_d = wr_sel_q;
    rd_sel_d = rd_sel_q;
    wr_cnt_d = wr_cnt_q;
    plane_d  = plane_q;
    if (in_fire) begin
      wr_cnt_d = wr_cnt_q + 1'b1;
    end
    if (grp_close) begin
      full_d[wr_sel_q]  = 1'b1;
      flast_d[wr_sel_q] = in_last;
      wr_sel_d          = !wr_sel_q;
      wr_cnt_d          = '0;
    end
    if (pl_fire) begin
      plane_d = plane_q + 1'b1;
    end
    if (grp_done) begin
      full_d[rd_sel_q] = 1'b0;
      rd_sel_d         = !rd_sel_q;
      plane_d          = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= '0;
      flast_q  <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      wr_cnt_q <= '0;
      plane_q  <= '0;
    end else begin
      full_q   <= full_d;
      flast_q  <= flast_d;
      wr_sel_q <= wr_sel_d;
      rd_sel_q <= rd_sel_d;
      wr_cnt_q <= wr_cnt_d;
      plane_q  <= plane_d;
    end
  end

  // Pixel storage; the first pixel of a group clears the other slots,
  // so a short final group is padded with zeros.
  always_ff @(posedge clk) begin
    if (in_fire) begin
      for (int b = 0; b < 2; b++) begin
        if (wr_sel_q == 1'(b)) begin
          for (int k = 0; k < GRP; k++) begin
            if (wr_cnt_q == CNT_W'(k))  mem_q[b][k] <= in_data;
            else if (wr_cnt_q == '0)    mem_q[b][k] <= '0;
          end
        end
      end
    end
  end

  // R8
  in_stall_both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (full_q == 2'b11));

  // R3
  frame_end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_last) |=> (wr_cnt_q == '0));
endmodule

// File: rtl/bpz_zrun_coder.sv
module bpz_zrun_coder
  import bpz_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned RUN_MAX = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            b_valid,
  output logic            b_ready,
  input  logic [BYTE_W-1:0] b_data,
  input  logic            b_last,
  output logic            tok_valid,
  input  logic            tok_ready,
  output logic [BYTE_W:0] tok_data
);
  localparam int unsigned RUN_W = $clog2(RUN_MAX);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_MAX - 1);

  logic [RUN_W-1:0] zcnt_q, zcnt_d;
  logic             out_v_q, out_v_d;
  logic [BYTE_W:0]  out_d_q, out_d_d;
  logic             space, nz, pend, flush, b_fire;

  assign space   = !out_v_q || tok_ready;
  assign nz      = |b_data;
  assign pend    = (zcnt_q != '0);
  assign flush   = b_valid && nz && pend && space;
  assign b_ready = space && !(nz && pend);
  assign b_fire  = b_valid && b_ready;

  always_comb begin
    zcnt_d  = zcnt_q;
    out_v_d = out_v_q && !tok_ready;
    out_d_d = out_d_q;
    if (flush) begin
      out_v_d = 1'b1;
      out_d_d = {TK_RUN, BYTE_W'(zcnt_q - 1'b1)};
      zcnt_d  = '0;
    end else if (b_fire) begin
      if (nz) begin
        out_v_d = 1'b1;
        out_d_d = {TK_LIT, b_data};
      end else if (b_last || (zcnt_q == RUN_LAST)) begin
        out_v_d = 1'b1;
        out_d_d = {TK_RUN, BYTE_W'(zcnt_q)};
        zcnt_d  = '0;
      end else begin
        zcnt_d  = zcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q  <= '0;
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      zcnt_q  <= zcnt_d;
      out_v_q <= out_v_d;
      out_d_q <= out_d_d;
    end
  end

  assign tok_valid = out_v_q;
  assign tok_data  = out_d_q;

  // R7
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_data)));

  // R4
  lit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && (tok_data[BYTE_W] == TK_LIT)) |-> (tok_data[BYTE_W-1:0] != '0));

  // R6
  flush_before_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fire && nz) |-> (zcnt_q == '0));

  // R5
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fire && !nz && (zcnt_q == RUN_LAST)) |=>
      (zcnt_q == '0 && tok_valid && tok_data[BYTE_W] == TK_RUN));
endmodule

// File: rtl/bpz_top.sv
module bpz_top #(
  parameter int unsigned PIX_W   = 16,
  parameter int unsigned GRP     = 8,
  parameter int unsigned RUN_MAX = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_last,
  output logic             tok_valid,
  input  logic             tok_ready,
  output logic [GRP:0]     tok_data
);
  logic           rst_n_s;
  logic           pl_valid, pl_ready, pl_last;
  logic [GRP-1:0] pl_data;

  bpz_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bpz_group_buf #(.PIX_W(PIX_W), .GRP(GRP)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .pl_valid (pl_valid),
    .pl_ready (pl_ready),
    .pl_data  (pl_data),
    .pl_last  (pl_last)
  );

  bpz_zrun_coder #(.BYTE_W(GRP), .RUN_MAX(RUN_MAX)) u_coder (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .b_valid   (pl_valid),
    .b_ready   (pl_ready),
    .b_data    (pl_data),
    .b_last    (pl_last),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_data  (tok_data)
  );
endmodule

// File: tb/sim_bpz_top.sv
`timescale 1ns/1ps
module sim_bpz_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        in_last;
  logic        tok_valid;
  logic        tok_ready;
  logic [8:0]  tok_data;

  bpz_top u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_data(tok_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0]  exp_q[$];
  logic [15:0] frm_q[$];
  int          ready_mode = 0;   // 0 always, 1 pseudo-random, 2 blocked
  bit          gap_en = 1'b0;
  bit          mon_en = 1'b0;
  int          acc_cnt = 0;
  bit [15:0]   lfsr = 16'hACE1;
  bit          prev_hold = 1'b0;
  logic [8:0]  prev_tok = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Reference: transpose with padding, then zero-run coding.
  task automatic model_frame();
    int n, ngrp, z;
    n = frm_q.size();
    ngrp = (n + 7) / 8;
    z = 0;
    for (int g = 0; g < ngrp; g++) begin
      for (int p = 0; p < 16; p++) begin
        logic [7:0] b;
        b = '0;
        for (int j = 0; j < 8; j++) begin
          int idx;
          idx = g * 8 + j;
          if (idx < n) b[j] = frm_q[idx][p];
        end
        if (b != 0) begin
          if (z > 0) exp_q.push_back({1'b1, 8'(z - 1)});
          z = 0;
          exp_q.push_back({1'b0, b});
        end else begin
          z++;
          if (z == 256) begin
            exp_q.push_back({1'b1, 8'd255});
            z = 0;
          end
        end
      end
    end
    if (z > 0) exp_q.push_back({1'b1, 8'(z - 1)});
  endtask

  task automatic send_frame();
    int n;
    model_frame();
    n = frm_q.size();
    for (int i = 0; i < n; i++) begin
      bit r;
      in_valid = 1'b1;
      in_data  = frm_q[i];
      in_last  = (i == n - 1);
      r = 1'b0;
      while (!r) begin
        @(negedge clk);
        r = in_ready;
        @(posedge clk);
        #1;
      end
      acc_cnt++;
      in_valid = 1'b0;
      if (gap_en && lfsr[3]) begin
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    frm_q.delete();
  endtask

  task automatic wait_drain(input string req);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || tok_valid) && t < 5000) begin
      @(posedge clk);
      #1;
      t++;
    end
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Output ready driver, off the edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: tok_ready = 1'b1;
      1: tok_ready = lfsr[0] | lfsr[5];
      default: tok_ready = 1'b0;
    endcase
  end

  // Cycle-by-cycle comparison against the reference queue.
  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_hold) begin
        // R7
        check(tok_valid && tok_data == prev_tok, "R7 hold", {tok_valid, tok_data}, {1'b1, prev_tok});
      end
      prev_hold = tok_valid && !tok_ready;
      prev_tok  = tok_data;
      if (tok_valid && tok_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 extra token", tok_data, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          // R2 plane order feeds both kinds; literals are R4, runs R5/R6
          if (e[8]) check(tok_data == e, "R2/R5/R6 run token", tok_data, e);
          else      check(tok_data == e, "R2/R4 literal token", tok_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_last = 1'b0;
    tok_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1
    check(tok_valid == 1'b0, "R1 tok_valid", tok_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    mon_en = 1'b1;

    // R3: single pixel, padded group -> literal 01 then run of 15
    frm_q.push_back(16'h0001);
    send_frame();
    wait_drain("R3 single pixel");

    // R2: pixel 3 carries only the top bit -> run of 15 then literal 08
    for (int i = 0; i < 5; i++) frm_q.push_back(i == 3 ? 16'h8000 : 16'h0000);
    send_frame();
    wait_drain("R2 bit placement");

    // R5: exactly 256 zero bytes -> one full run, nothing left over
    for (int i = 0; i < 128; i++) frm_q.push_back(16'h0000);
    send_frame();
    wait_drain("R5 run of 256");

    // R5: 320 zero bytes -> full run plus remainder
    for (int i = 0; i < 160; i++) frm_q.push_back(16'h0000);
    send_frame();
    wait_drain("R5 run over 256");

    // R4: dense data, all literals
    for (int i = 0; i < 24; i++) frm_q.push_back(16'hFFFF);
    send_frame();
    wait_drain("R4 dense");

    // R6: sparse small values, runs split by literals and flushed at frame end
    for (int i = 0; i < 64; i++) frm_q.push_back(16'((i * 7) % 13));
    send_frame();
    wait_drain("R6 sparse");

    // R8: output blocked, nonzero bytes: exactly 16 pixels accepted
    ready_mode = 2;
    acc_cnt = 0;
    for (int i = 0; i < 24; i++) frm_q.push_back(16'hFFFF);
    fork
      send_frame();
      begin
        repeat (100) @(posedge clk);
        #1;
        check(acc_cnt == 16, "R8 stall depth", acc_cnt, 16);
        check(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
        ready_mode = 0;
      end
    join
    wait_drain("R8 drain");

    // R9: mixed frames, input gaps, random backpressure
    ready_mode = 1;
    gap_en = 1'b1;
    for (int f = 0; f < 6; f++) begin
      int len;
      len = 3 + f * 29;
      for (int i = 0; i < len; i++) begin
        logic [15:0] v;
        v = 16'((i * 37 + f * 11) & 16'h001F);
        if ((i % 17) == 5) v = v | 16'h0400;
        if ((i % 9) == 0)  v = 16'h0000;
        frm_q.push_back(v);
      end
      send_frame();
    end
    wait_drain("R9 mixed");

    ready_mode = 0;
    gap_en = 1'b0;
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule